// File: doc/BRIEF.md
# Dual-Address Two-Wire Memory Slave

This block is a slave on a two-wire serial bus (I2C style). It answers two device addresses, and each address selects a separate 256-byte map of 8-bit words. The identification map is read-only. It holds a fixed pattern that is computed from the byte address. The diagnostic map holds monitored values and alarm or warning flags in its lower half. Its upper half is a user area that the host may write.

Internal logic refreshes the lower half of the diagnostic map through a valid/ready side port. A beat transfers when `upd_valid_i` and `upd_ready_o` are both high on a rising clock edge. `upd_ready_o` stays low from a detected start condition until the matching stop, so the port is back-pressured for the whole of a transaction and a multi-byte read never returns a mix of old and new values. A source with no room to wait can hold `upd_valid_i` high with its beat stable until the transfer. The bus pins are sampled through a synchronizer on the system clock. The slave never stretches SCL.

Top module: `i2cm_dual_slave`

## Requirements
- R1: After reset, `sda_pull_o` is 0, `upd_ready_o` is 1, both word pointers are 0 and every diagnostic byte is 0x00.
- R2: The slave acknowledges an address byte only when it is 0xA0/0xA1 (identification map) or 0xA2/0xA3 (diagnostic map); bit 0 is 1 for a read. It acknowledges by pulling SDA low during the ninth clock. For any other address it leaves SDA released until the next start.
- R3: SDA is sampled on rising SCL edges, and `sda_pull_o` changes only while SCL is low.
- R4: SDA falling while SCL is high is a start, which also works as a repeated start. SDA rising while SCL is high is a stop, which ends the transaction and releases SDA.
- R5: The first data byte after a write-addressed frame loads that map's word pointer. A repeated start with a read address then reads from that pointer.
- R6: Each data byte transferred increments the word pointer, in reads and in writes, and the pointer wraps from 255 to 0.
- R7: Each map keeps its own word pointer, so a read with no pointer load continues from where that map was left.
- R8: Data bytes written to the identification map are acknowledged and discarded.
- R9: Host writes to diagnostic bytes 128..255 are stored. Host writes to bytes 0..127 are acknowledged and discarded.
- R10: A side-port beat (7-bit address, 8-bit data) is accepted only while `upd_ready_o` is 1 and writes diagnostic byte 0..127. `upd_ready_o` is 0 between a start and the following stop.
- R11: When the host answers a read byte with NACK (SDA high in the ninth clock), the slave releases SDA and sends nothing more until a new start.
- R12: Identification byte k reads as k XOR ID_SEED (default 0x3C).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock level seen on the bus |
| sda_i | input | 1 | Serial data level seen on the bus |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain driver enable) |
| upd_valid_i | input | 1 | Side-port beat valid |
| upd_ready_o | output | 1 | Side port can accept a beat (no transaction open) |
| upd_addr_i | input | 7 | Side-port diagnostic byte address (0..127) |
| upd_data_i | input | 8 | Side-port data byte |

## Verification
The tests cover random reads after a pointer load, sequential reads across the 255-to-0 boundary, and current-address reads that use no pointer load. The last kind separates per-map pointers from one shared pointer. Writes go to the identification map, to the protected diagnostic half and to the writable diagnostic half, including one burst that wraps from the writable half into the protected half. Each is read back, which shows that a write was acknowledged and also stored or discarded. Other tests send an unknown device address, end a read with NACK, and offer a side-port beat during an open transaction. The first must not be acknowledged, the second must release SDA, and the third must be refused.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } link_st_e;

  // identification pattern: address folded with a fixed seed
  function automatic logic [7:0] id_byte(input logic [7:0] addr, input logic [7:0] seed);
    return addr ^ seed;
  endfunction

endpackage

// File: rtl/i2cm_bus_sync.sv
module i2cm_bus_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int PIPE_W = SYNC_STAGES + 1;

  logic [PIPE_W-1:0] scl_pipe, sda_pipe;
  logic scl_prev, sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
    end else begin
      scl_pipe <= {scl_pipe[PIPE_W-2:0], scl_i};
      sda_pipe <= {sda_pipe[PIPE_W-2:0], sda_i};
    end
  end

  assign scl_s    = scl_pipe[SYNC_STAGES-1];
  assign sda_s    = sda_pipe[SYNC_STAGES-1];
  assign scl_prev = scl_pipe[SYNC_STAGES];
  assign sda_prev = sda_pipe[SYNC_STAGES];

  assign scl_rise  = scl_s & ~scl_prev;
  assign scl_fall  = ~scl_s & scl_prev;
  assign start_det = scl_s & scl_prev & sda_prev & ~sda_s;
  assign stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;

endmodule

// File: rtl/i2cm_diag_mem.sv
module i2cm_diag_mem #(
  parameter int AW           = 8,
  parameter int HOST_WR_BASE = 128
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    host_we,
  input  logic [AW-1:0]           host_addr,
  input  logic [7:0]              host_wdata,
  input  logic                    side_we,
  input  logic [$clog2(HOST_WR_BASE)-1:0] side_addr,
  input  logic [7:0]              side_wdata,
  input  logic [AW-1:0]           rd_addr,
  output logic [7:0]              rd_data
);
  localparam int DEPTH   = 1 << AW;
  localparam int SIDE_AW = $clog2(HOST_WR_BASE);
  localparam logic [AW-1:0] BASE_A = AW'(HOST_WR_BASE);

  logic [7:0] mem [DEPTH];
  logic       host_ok;
  logic [AW-1:0] side_full;

  assign host_ok   = host_we && (host_addr >= BASE_A);
  assign side_full = AW'(side_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (side_we) mem[side_full] <= side_wdata;
      if (host_ok) mem[host_addr] <= host_wdata;
    end
  end

  assign rd_data = mem[rd_addr];

  logic unused_w;
  assign unused_w = ^{SIDE_AW[0]};

endmodule

// File: rtl/i2cm_link.sv
module i2cm_link
  import i2cm_pkg::*;
#(
  parameter int         AW         = 8,
  parameter logic [6:0] ID_ADDR7   = 7'h50,
  parameter logic [6:0] DIAG_ADDR7 = 7'h51
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          sda_s,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [7:0]    rd_data,
  output logic          busy,
  output logic          sda_pull,
  output logic          map_sel,
  output logic [AW-1:0] cur_ptr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data
);
  localparam int NMAPS = 2;

  link_st_e      state;
  logic [3:0]    bitcnt;
  logic [7:0]    shreg, txbyte, rx_byte;
  logic          rw, first_byte, phase;
  logic [AW-1:0] ptr [NMAPS];

  assign rx_byte = {shreg[6:0], sda_s};
  assign cur_ptr = ptr[map_sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      bitcnt     <= '0;
      shreg      <= '0;
      txbyte     <= '0;
      rw         <= 1'b0;
      first_byte <= 1'b0;
      phase      <= 1'b0;
      busy       <= 1'b0;
      sda_pull   <= 1'b0;
      map_sel    <= 1'b0;
      wr_en      <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
      for (int m = 0; m < NMAPS; m++) ptr[m] <= '0;
    end else begin
      wr_en <= 1'b0;
      if (stop_det) begin
        state    <= ST_IDLE;
        busy     <= 1'b0;
        sda_pull <= 1'b0;
        phase    <= 1'b0;
      end else if (start_det) begin
        state      <= ST_ADDR;
        busy       <= 1'b1;
        sda_pull   <= 1'b0;
        bitcnt     <= '0;
        first_byte <= 1'b1;
        phase      <= 1'b0;
      end else begin
        unique case (state)
          ST_IDLE: ;
          ST_ADDR: if (scl_rise) begin
            shreg  <= rx_byte;
            bitcnt <= bitcnt + 4'd1;
            if (bitcnt == 4'd7) begin
              bitcnt <= '0;
              rw     <= rx_byte[0];
              if (rx_byte[7:1] == ID_ADDR7) begin
                map_sel <= 1'b0;
                state   <= ST_ADDR_ACK;
              end else if (rx_byte[7:1] == DIAG_ADDR7) begin
                map_sel <= 1'b1;
                state   <= ST_ADDR_ACK;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_ADDR_ACK: if (scl_fall) begin
            if (!phase) begin
              phase    <= 1'b1;
              sda_pull <= 1'b1;
            end else begin
              phase  <= 1'b0;
              bitcnt <= '0;
              if (rw) begin
                txbyte   <= rd_data;
                sda_pull <= ~rd_data[7];
                state    <= ST_RD;
              end else begin
                sda_pull <= 1'b0;
                state    <= ST_WR;
              end
            end
          end
          ST_WR: if (scl_rise) begin
            shreg  <= rx_byte;
            bitcnt <= bitcnt + 4'd1;
            if (bitcnt == 4'd7) begin
              bitcnt <= '0;
              state  <= ST_WR_ACK;
              if (first_byte) begin
                first_byte   <= 1'b0;
                ptr[map_sel] <= AW'(rx_byte);
              end else begin
                wr_en        <= map_sel;
                wr_addr      <= cur_ptr;
                wr_data      <= rx_byte;
                ptr[map_sel] <= cur_ptr + 1'b1;
              end
            end
          end
          ST_WR_ACK: if (scl_fall) begin
            if (!phase) begin
              phase    <= 1'b1;
              sda_pull <= 1'b1;
            end else begin
              phase    <= 1'b0;
              sda_pull <= 1'b0;
              state    <= ST_WR;
            end
          end
          ST_RD: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 4'd1;
              if (bitcnt == 4'd7) ptr[map_sel] <= cur_ptr + 1'b1;
            end else if (scl_fall) begin
              if (bitcnt == 4'd8) begin
                sda_pull <= 1'b0;
                state    <= ST_RD_ACK;
              end else begin
                txbyte   <= {txbyte[6:0], 1'b0};
                sda_pull <= ~txbyte[6];
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) begin
              if (sda_s) state <= ST_IDLE;
              else       phase <= 1'b1;
            end else if (scl_fall && phase) begin
              phase    <= 1'b0;
              bitcnt   <= '0;
              txbyte   <= rd_data;
              sda_pull <= ~rd_data[7];
              state    <= ST_RD;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2cm_dual_slave.sv
module i2cm_dual_slave
  import i2cm_pkg::*;
#(
  parameter int         AW           = 8,
  parameter logic [6:0] ID_ADDR7     = 7'h50,
  parameter logic [6:0] DIAG_ADDR7   = 7'h51,
  parameter int         HOST_WR_BASE = 128,
  parameter logic [7:0] ID_SEED      = 8'h3C,
  parameter int         SYNC_STAGES  = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            scl_i,
  input  logic                            sda_i,
  output logic                            sda_pull_o,
  input  logic                            upd_valid_i,
  output logic                            upd_ready_o,
  input  logic [$clog2(HOST_WR_BASE)-1:0] upd_addr_i,
  input  logic [7:0]                      upd_data_i
);
  logic          scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic          busy, map_sel, wr_en;
  logic [AW-1:0] cur_ptr, wr_addr;
  logic [7:0]    wr_data, diag_rd, rd_data;

  i2cm_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2cm_link #(.AW(AW), .ID_ADDR7(ID_ADDR7), .DIAG_ADDR7(DIAG_ADDR7)) u_link (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_s(sda_s), .start_det(start_det), .stop_det(stop_det),
    .rd_data(rd_data), .busy(busy), .sda_pull(sda_pull_o), .map_sel(map_sel),
    .cur_ptr(cur_ptr), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  assign upd_ready_o = ~busy;

  i2cm_diag_mem #(.AW(AW), .HOST_WR_BASE(HOST_WR_BASE)) u_diag (
    .clk(clk), .rst_n(rst_n),
    .host_we(wr_en), .host_addr(wr_addr), .host_wdata(wr_data),
    .side_we(upd_valid_i & upd_ready_o), .side_addr(upd_addr_i), .side_wdata(upd_data_i),
    .rd_addr(cur_ptr), .rd_data(diag_rd)
  );

  assign rd_data = map_sel ? diag_rd : id_byte(8'(cur_ptr), ID_SEED);

endmodule

// File: rtl/i2cm_dual_slave_chk.sv
module i2cm_dual_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic start_det,
  input logic stop_det,
  input logic sda_pull,
  input logic upd_ready
);
  // R3: the SDA driver moves only while the synchronized SCL is low
  assert_pull_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> !scl_s);

  // R4: a stop releases SDA on the next cycle
  assert_stop_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_pull);

  // R10: a start closes the side port
  assert_start_blocks_side_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !upd_ready);

  // R10: a stop reopens the side port
  assert_stop_opens_side_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> upd_ready);

  // R2: SDA is pulled only inside an open transaction
  assert_pull_in_txn_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pull |-> !upd_ready);
endmodule

bind i2cm_dual_slave i2cm_dual_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_det(start_det),
  .stop_det(stop_det), .sda_pull(sda_pull_o), .upd_ready(upd_ready_o)
);

// File: tb/test_i2cm_dual_slave.sv
`timescale 1ns/1ps
module test_i2cm_dual_slave;
  localparam int         Q    = 10;
  localparam logic [7:0] SEED = 8'h3C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_scl = 1'b1;
  logic host_low = 1'b0;
  logic sda_line, sda_pull_o, upd_ready_o;
  logic upd_valid_i = 1'b0;
  logic [6:0] upd_addr_i = '0;
  logic [7:0] upd_data_i = '0;

  int checks = 0;
  int errors = 0;
  int r3_viol = 0;
  logic prev_pull = 1'b0;

  always #2.5 clk = ~clk;

  assign sda_line = ~(host_low | sda_pull_o);

  i2cm_dual_slave i_i2cm_dual_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(host_scl), .sda_i(sda_line),
    .sda_pull_o(sda_pull_o), .upd_valid_i(upd_valid_i), .upd_ready_o(upd_ready_o),
    .upd_addr_i(upd_addr_i), .upd_data_i(upd_data_i)
  );

  // R3 monitor: driver must not move while SCL is high
  always @(posedge clk) begin
    if (rst_n && host_scl && (sda_pull_o != prev_pull)) r3_viol++;
    prev_pull <= sda_pull_o;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_start;
    host_low = 1'b0; tick(Q);
    host_scl = 1'b1; tick(Q);
    host_low = 1'b1; tick(Q);
    host_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop;
    host_scl = 1'b0; host_low = 1'b1; tick(Q);
    host_scl = 1'b1; tick(Q);
    host_low = 1'b0; tick(Q);
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      host_low = ~b[i]; tick(Q);
      host_scl = 1'b1;  tick(2*Q);
      host_scl = 1'b0;  tick(Q);
    end
    host_low = 1'b0; tick(Q);
    host_scl = 1'b1; tick(Q);
    ack = ~sda_line; tick(Q);
    host_scl = 1'b0; tick(Q);
  endtask

  task automatic rbyte(input logic nack, output logic [7:0] d);
    host_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      tick(Q);
      host_scl = 1'b1; tick(Q);
      d[i] = sda_line; tick(Q);
      host_scl = 1'b0;
    end
    host_low = ~nack; tick(Q);
    host_scl = 1'b1; tick(2*Q);
    host_scl = 1'b0; tick(2);
    host_low = 1'b0;
  endtask

  // pointer load, repeated start, n-byte read (last NACKed)
  task automatic read_at(input logic [7:0] dev, input logic [7:0] p, input int n,
                         output logic [7:0] got [4]);
    logic a;
    bus_start; wbyte(dev, a); wbyte(p, a);
    bus_start; wbyte(dev | 8'h01, a);
    for (int k = 0; k < n; k++) rbyte(k == n-1, got[k]);
    bus_stop;
  endtask

  task automatic side_put(input logic [6:0] a, input logic [7:0] d);
    upd_addr_i = a; upd_data_i = d; upd_valid_i = 1'b1;
    chk("R10 side ready idle", {7'd0, upd_ready_o}, 8'h01);
    tick(1);
    upd_valid_i = 1'b0; tick(2);
  endtask

  task automatic sc_reset;
    chk("R1 pull after reset", {7'd0, sda_pull_o}, 8'h00);
    chk("R1 ready after reset", {7'd0, upd_ready_o}, 8'h01);
  endtask

  task automatic sc_side_port;
    side_put(7'h00, 8'h5A);
    side_put(7'h20, 8'h99);
    bus_start;
    upd_addr_i = 7'h21; upd_data_i = 8'hEE; upd_valid_i = 1'b1;
    tick(5);
    chk("R10 ready low in txn", {7'd0, upd_ready_o}, 8'h00);
    upd_valid_i = 1'b0;
    bus_stop; tick(4);
    chk("R10 ready back after stop", {7'd0, upd_ready_o}, 8'h01);
  endtask

  task automatic sc_id_read;
    logic a;
    logic [7:0] g [4];
    bus_start; wbyte(8'hA0, a);
    chk("R2 ack id write addr", {7'd0, a}, 8'h01);
    wbyte(8'h10, a);
    chk("R5 ack pointer byte", {7'd0, a}, 8'h01);
    bus_start; wbyte(8'hA1, a);
    chk("R2 ack id read addr", {7'd0, a}, 8'h01);
    rbyte(1'b0, g[0]); rbyte(1'b0, g[1]); rbyte(1'b1, g[2]);
    chk("R5 R12 random read", g[0], 8'h10 ^ SEED);
    chk("R6 seq read +1", g[1], 8'h11 ^ SEED);
    chk("R6 seq read +2", g[2], 8'h12 ^ SEED);
    tick(Q);
    chk("R11 released after nack", {7'd0, sda_pull_o}, 8'h00);
    host_scl = 1'b1; tick(Q);
    chk("R11 no data after nack", {7'd0, sda_line}, 8'h01);
    host_scl = 1'b0; tick(Q);
    bus_stop;
    read_at(8'hA0, 8'hFF, 2, g);
    chk("R6 id byte 255", g[0], 8'hFF ^ SEED);
    chk("R6 id wrap to 0", g[1], 8'h00 ^ SEED);
  endtask

  task automatic sc_id_write;
    logic a;
    logic [7:0] g [4];
    bus_start; wbyte(8'hA0, a); wbyte(8'h05, a); wbyte(8'hAA, a);
    chk("R8 id data acked", {7'd0, a}, 8'h01);
    bus_stop;
    read_at(8'hA0, 8'h05, 1, g);
    chk("R8 id write discarded", g[0], 8'h05 ^ SEED);
  endtask

  task automatic sc_bad_addr;
    logic a;
    bus_start; wbyte(8'hA4, a);
    chk("R2 no ack foreign addr", {7'd0, a}, 8'h00);
    chk("R2 released foreign", {7'd0, sda_pull_o}, 8'h00);
    bus_stop;
  endtask

  task automatic sc_diag_upper;
    logic a;
    logic [7:0] g [4];
    bus_start; wbyte(8'hA2, a); wbyte(8'hFE, a);
    wbyte(8'h11, a); wbyte(8'h22, a); wbyte(8'h33, a);
    chk("R9 protected byte acked", {7'd0, a}, 8'h01);
    bus_stop;
    read_at(8'hA2, 8'hFE, 3, g);
    chk("R9 stored 0xFE", g[0], 8'h11);
    chk("R9 stored 0xFF", g[1], 8'h22);
    chk("R6 R9 wrap into protected", g[2], 8'h5A);
  endtask

  task automatic sc_diag_lower;
    logic a;
    logic [7:0] g [4];
    bus_start; wbyte(8'hA2, a); wbyte(8'h20, a); wbyte(8'h77, a);
    bus_stop;
    read_at(8'hA2, 8'h20, 2, g);
    chk("R9 R10 lower kept side value", g[0], 8'h99);
    chk("R10 refused beat not stored", g[1], 8'h00);
  endtask

  task automatic sc_ptrs;
    logic a;
    logic [7:0] d;
    bus_start; wbyte(8'hA2, a); wbyte(8'h90, a); wbyte(8'h66, a); bus_stop;
    bus_start; wbyte(8'hA2, a); wbyte(8'h90, a); bus_stop;
    bus_start; wbyte(8'hA0, a); wbyte(8'h40, a); bus_stop;
    bus_start; wbyte(8'hA3, a); rbyte(1'b1, d); bus_stop;
    chk("R7 diag pointer kept", d, 8'h66);
    bus_start; wbyte(8'hA1, a); rbyte(1'b1, d); bus_stop;
    chk("R7 id pointer kept", d, 8'h40 ^ SEED);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(5);
    sc_reset;
    sc_side_port;
    sc_id_read;
    sc_id_write;
    sc_bad_addr;
    sc_diag_upper;
    sc_diag_lower;
    sc_ptrs;
    chk("R3 pull moved with SCL high", 8'(r3_viol), 8'h00);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule